// File: doc/BRIEF.md
# DMA Request to Bus-Grant Sequencer

This block sits between seven legacy peripheral DMA request lines and a host bus. When a peripheral raises its request, the sequencer picks one channel by fixed priority, locks that choice, and raises a bus request toward an external host-bus arbiter. The acknowledge for the chosen channel is driven low only once the arbiter has granted the bus. Until then the peripheral has to wait. Transfers always target system memory, so nothing else has to be decided before ownership is requested.

There are eight channel numbers in the scheme, but number 4 has no line. Channels 0 to 3 move bytes and channels 5 to 7 move 16-bit words. While a channel owns the bus, the block reports its channel number and its transfer width. The request line of the owning channel controls how long ownership lasts. When that line drops, the acknowledge and the bus request are both released one cycle later.

Top module: `dmaGrantSeq`

## Requirements
- R1: During and directly after reset, `hostBusReq` is 0, every bit of `ackN` is 1, and `actChan` and `actWide` are 0.
- R2: If `reqLines` is nonzero while the block is idle, `hostBusReq` is 1 after the next rising clock edge.
- R3: An acknowledge goes low only on the edge after `hostGrant` is sampled high while the bus request is pending and the chosen request is still high.
- R4: Among pending lines the lowest bit index of `reqLines` wins. The choice is locked on the edge that raises `hostBusReq`, and requests that arrive later on other lines do not displace it.
- R5: Lines map to channels as follows: bits 0 to 3 of `reqLines` and `ackN` are channels 0 to 3, and bits 4, 5 and 6 are channels 5, 6 and 7.
- R6: While an acknowledge is low, `actChan` holds the owning channel number (0 to 3 or 5 to 7). `actWide` is 0 for channels 0 to 3 and 1 for channels 5 to 7.
- R7: An acknowledge stays low for as long as its request line stays high, whatever `hostGrant` does.
- R8: When the owning line is sampled low, the edge that follows returns all of `ackN` to 1 and sets `hostBusReq` to 0.
- R9: A grant sampled while no request is pending is ignored: no acknowledge and no bus request follow from it.
- R10: If the chosen line drops before the grant arrives, `hostBusReq` falls on the next edge and no acknowledge is produced.
- R11: At most one bit of `ackN` is low at any time. Whenever a bit is low, `hostBusReq` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqLines | input | 7 | Active-high peripheral requests, mapped as in R5 |
| hostGrant | input | 1 | Host-bus grant from the arbiter |
| hostBusReq | output | 1 | Bus request to the arbiter |
| ackN | output | 7 | Active-low acknowledges, one per request line |
| actChan | output | 3 | Owning channel number, valid while an acknowledge is low |
| actWide | output | 1 | 1 for a 16-bit channel, 0 for an 8-bit channel |

## Verification
The assertions check several rules on every cycle:
- at most one acknowledge is low, and only while the bus request is up;
- an acknowledge only goes low after a grant;
- an acknowledge holds while its line stays high;
- the release follows one cycle after the owning line drops;
- the width flag agrees with the line that is acknowledged.

Other behaviours depend on a particular order of stimuli, and only the bench scenarios can show them:
- which line wins a contested priority pick;
- that the locked choice survives a newer, higher-priority request;
- that a grant arriving while idle has no effect;
- that a request withdrawn before its grant leaves no trace.

// File: rtl/dmaSeqPkg.sv
package dmaSeqPkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_OWN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;  // lock the priority winner
    logic own;      // bus granted, acknowledge active
  } seqStrobe_t;
endpackage

// File: rtl/dmaSeqCtrl.sv
module dmaSeqCtrl
  import dmaSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       selLive,
  input  logic       hostGrant,
  output seqStrobe_t strobe,
  output logic       busReqOut
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE: if (anyReq) stateNext = SEQ_WAIT;
      SEQ_WAIT: begin
        if (!selLive)       stateNext = SEQ_IDLE;
        else if (hostGrant) stateNext = SEQ_OWN;
      end
      SEQ_OWN:  if (!selLive) stateNext = SEQ_IDLE;
      default:  stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.capture = (state == SEQ_IDLE) && anyReq;
    strobe.own     = (state == SEQ_OWN);
    busReqOut      = (state != SEQ_IDLE);
  end
endmodule

// File: rtl/dmaSeqPath.sv
module dmaSeqPath
  import dmaSeqPkg::*;
#(
  parameter int NARROW_CH = 4,
  parameter int WIDE_CH   = 3,
  localparam int LINES    = NARROW_CH + WIDE_CH,
  localparam int IDX_W    = $clog2(LINES),
  localparam int CHAN_W   = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  reqLines,
  input  seqStrobe_t        strobe,
  output logic              anyReq,
  output logic              selLive,
  output logic [LINES-1:0]  ackN,
  output logic [CHAN_W-1:0] actChan,
  output logic              actWide
);
  logic [IDX_W-1:0]  pickIdx, selIdx;
  logic [LINES-1:0]  selHot;
  logic [CHAN_W-1:0] chanNum;
  logic              isWide;

  // fixed priority: the lowest index is assigned last and so wins
  always_comb begin
    pickIdx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (reqLines[i]) pickIdx = IDX_W'(i);
    end
  end

  assign anyReq = |reqLines;

  always_ff @(posedge clk) begin
    if (!rstN)               selIdx <= '0;
    else if (strobe.capture) selIdx <= pickIdx;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_lineDecode
    assign selHot[g] = (selIdx == IDX_W'(g));
    assign ackN[g]   = ~(selHot[g] & strobe.own);
  end

  assign selLive = |(selHot & reqLines);

  // the channel number skips the missing slot that sits after the narrow group
  assign isWide  = (selIdx >= IDX_W'(NARROW_CH));
  assign chanNum = isWide ? CHAN_W'(selIdx) + CHAN_W'(1) : CHAN_W'(selIdx);
  assign actChan = strobe.own ? chanNum : '0;
  assign actWide = strobe.own & isWide;
endmodule

// File: rtl/dmaGrantSeq.sv
module dmaGrantSeq
  import dmaSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] reqLines,
  input  logic       hostGrant,
  output logic       hostBusReq,
  output logic [6:0] ackN,
  output logic [2:0] actChan,
  output logic       actWide
);
  seqStrobe_t strobe;
  logic       anyReq;
  logic       selLive;

  dmaSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (anyReq),
    .selLive   (selLive),
    .hostGrant (hostGrant),
    .strobe    (strobe),
    .busReqOut (hostBusReq)
  );

  dmaSeqPath #(.NARROW_CH(4), .WIDE_CH(3)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .reqLines (reqLines),
    .strobe   (strobe),
    .anyReq   (anyReq),
    .selLive  (selLive),
    .ackN     (ackN),
    .actChan  (actChan),
    .actWide  (actWide)
  );
endmodule

// File: rtl/dmaSeqChecker.sv
module dmaSeqChecker (
  input logic       clk,
  input logic       rstN,
  input logic [6:0] reqLines,
  input logic       hostGrant,
  input logic       hostBusReq,
  input logic [6:0] ackN,
  input logic [2:0] actChan,
  input logic       actWide
);
  logic ackAny;
  assign ackAny = (ackN != 7'h7f);

  assert_single_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ackN));

  assert_ack_needs_busreq_R11: assert property (@(posedge clk) disable iff (!rstN)
    ackAny |-> hostBusReq);

  assert_ack_after_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackAny) |-> $past(hostGrant) && $past(hostBusReq));

  assert_busreq_from_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostBusReq) |-> $past(|reqLines));

  assert_ack_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((~ackN & reqLines) != 7'h00) |=> $stable(ackN));

  assert_release_next_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackAny && ((~ackN & reqLines) == 7'h00)) |=> (ackN == 7'h7f) && !hostBusReq);

  assert_width_matches_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackAny |-> (actWide == (ackN[6:4] != 3'b111)));

  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ackAny |-> (actChan == 3'd0) && !actWide);
endmodule

bind dmaGrantSeq dmaSeqChecker u_chk (.*);

// File: tb/dmaGrantSeq_tb.sv
module dmaGrantSeq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] reqLines = '0;
  logic       hostGrant = 1'b0;
  logic       hostBusReq;
  logic [6:0] ackN;
  logic [2:0] actChan;
  logic       actWide;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    logic       busReq;
    logic [6:0] ackN;
    logic [2:0] chan;
    logic       wide;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;

  dmaGrantSeq u_dut (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .hostGrant(hostGrant),
    .hostBusReq(hostBusReq), .ackN(ackN), .actChan(actChan), .actWide(actWide)
  );

  function automatic void compare(expItem_t e);
    compared++;
    if (hostBusReq !== e.busReq || ackN !== e.ackN || actChan !== e.chan || actWide !== e.wide) begin
      mismatched++;
      $display("FAIL %s: got busReq=%b ackN=%b chan=%0d wide=%b, expected busReq=%b ackN=%b chan=%0d wide=%b",
               e.tag, hostBusReq, ackN, actChan, actWide, e.busReq, e.ackN, e.chan, e.wide);
    end
  endfunction

  // driver: apply one cycle of stimulus and queue what must show after the next edge
  // ackLine < 0 means no acknowledge; mapping follows R5
  task automatic cyc(input logic [6:0] r, input logic g, input logic br,
                     input int ackLine, input string tag);
    expItem_t e;
    @(negedge clk);
    reqLines  = r;
    hostGrant = g;
    e.busReq = br;
    e.ackN   = 7'h7f;
    e.chan   = 3'd0;
    e.wide   = 1'b0;
    e.tag    = tag;
    if (ackLine >= 0) begin
      e.ackN[ackLine] = 1'b0;
      e.chan = (ackLine < 4) ? 3'(ackLine) : 3'(ackLine + 1);
      e.wide = (ackLine >= 4);
    end
    expQ.push_back(e);
  endtask

  // monitor: sample shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    expItem_t r1;
    repeat (3) @(posedge clk);
    r1.busReq = 1'b0; r1.ackN = 7'h7f; r1.chan = 3'd0; r1.wide = 1'b0; r1.tag = "R1 in reset";
    #2 compare(r1);
    @(negedge clk);
    rstN = 1'b1;
    cyc(7'h00, 1'b0, 1'b0, -1, "R1 after reset");

    // basic request, grant, hold, release on line 0
    cyc(7'h01, 1'b0, 1'b1, -1, "R2 busreq raised");
    cyc(7'h01, 1'b0, 1'b1, -1, "R3 waits for grant");
    cyc(7'h01, 1'b1, 1'b1,  0, "R3 ack after grant");
    cyc(7'h01, 1'b1, 1'b1,  0, "R6 channel 0 narrow");
    cyc(7'h00, 1'b0, 1'b0, -1, "R8 release");
    cyc(7'h00, 1'b0, 1'b0, -1, "R8 stays idle");

    // contested pick of lines 4 and 6 (channels 5 and 7)
    cyc(7'h50, 1'b0, 1'b1, -1, "R2 busreq for wide lines");
    cyc(7'h50, 1'b1, 1'b1,  4, "R4 lowest line wins ch5");
    cyc(7'h52, 1'b1, 1'b1,  4, "R4 later line1 does not displace");
    cyc(7'h42, 1'b0, 1'b0, -1, "R8 release ch5");
    cyc(7'h42, 1'b0, 1'b1, -1, "R2 re-request");
    cyc(7'h42, 1'b1, 1'b1,  1, "R5 line1 is ch1");
    cyc(7'h00, 1'b0, 1'b0, -1, "R8 release ch1");

    // choice locked before grant
    cyc(7'h40, 1'b0, 1'b1, -1, "R2 line6 request");
    cyc(7'h41, 1'b0, 1'b1, -1, "R4 locked before grant");
    cyc(7'h41, 1'b1, 1'b1,  6, "R4 ch7 keeps ownership");
    cyc(7'h41, 1'b1, 1'b1,  6, "R11 single ack ch7");
    cyc(7'h00, 1'b0, 1'b0, -1, "R8 release ch7");

    // grant with nothing pending
    cyc(7'h00, 1'b1, 1'b0, -1, "R9 idle grant ignored");
    cyc(7'h00, 1'b1, 1'b0, -1, "R9 idle grant ignored again");
    cyc(7'h08, 1'b1, 1'b1, -1, "R9 grant while idle gives no ack");
    cyc(7'h08, 1'b1, 1'b1,  3, "R5 line3 is ch3");
    cyc(7'h00, 1'b1, 1'b0, -1, "R8 release ch3");

    // request withdrawn before grant
    cyc(7'h04, 1'b0, 1'b1, -1, "R10 line2 request");
    cyc(7'h00, 1'b0, 1'b0, -1, "R10 busreq drops");
    cyc(7'h00, 1'b1, 1'b0, -1, "R10 late grant no ack");

    // acknowledge held while grant goes away
    cyc(7'h20, 1'b1, 1'b1, -1, "R7 line5 request");
    cyc(7'h20, 1'b1, 1'b1,  5, "R6 ch6 wide");
    cyc(7'h20, 1'b0, 1'b1,  5, "R7 held without grant");
    cyc(7'h20, 1'b0, 1'b1,  5, "R7 still held");
    cyc(7'h00, 1'b0, 1'b0, -1, "R8 release ch6");
    cyc(7'h00, 1'b0, 1'b0, -1, "R11 idle after all");

    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule